// File: doc/BRIEF.md
# Three-Channel Reload Down-Counter Timer

The block holds three independent 32-bit down-counters behind one synchronous register bus. Each channel has a reload value, a live count and a control word. A shared start word holds one run bit per channel. Each running channel loses one count per tick of its chosen source. The source is a tap of one shared free-running prescaler, or a one-cycle pulse on the RTC tick input, or a one-cycle pulse on the external tick input.

When a tick arrives while the count is zero, the channel reloads from its reload value and raises a sticky underflow flag. The channel's interrupt line is high while that flag and the channel's interrupt enable are both set. Software may clear the flag but can never set it. A count write by software wins over a decrement or reload in the same cycle.

Top module: `tmr3_top`

## Requirements
- R1: After reset every register reads 0 and all three interrupt lines are low.
- R2: Byte addresses are decoded on 32-bit words. The start word is at 0x00, with run bits 0..2 for channels 0..2. Channel n starts at 0x04+12n, holding the reload value at +0, the count at +4 and the control word at +8. Reads return the stored value. The control word reads back bits 2:0 (source), bit 5 (interrupt enable) and bit 8 (underflow flag), with all other bits 0. Addresses that are unmapped or not word-aligned read 0 and ignore writes.
- R3: While its run bit is 1, a channel's count drops by one on each tick of its selected source, and a read of the count returns the current value.
- R4: While its run bit is 0, a channel's count holds its value whatever ticks arrive.
- R5: A tick that arrives with the count at 0 loads the reload value into the count and sets control bit 8.
- R6: Writing 0 to control bit 8 clears the flag. Writing 1 leaves the flag as it was, so a write never sets it.
- R7: A channel's interrupt line is 1 exactly when its control bits 8 and 5 are both 1.
- R8: Source codes 0..4 tick once every 4, 16, 64, 256 and 1024 clock cycles, taken from one prescaler counter shared by all channels. Code 5 ticks once every 4096 cycles.
- R9: Source code 6 counts one-cycle pulses on `rtc_tick`, and code 7 counts one-cycle pulses on `ext_tick`. Each channel ignores the sources it has not selected.
- R10: A count write in the same cycle as a tick stores the written value, and no underflow flag is set from that tick.
- R11: The channels are independent, so ticks and writes for one channel leave the other channels' counts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the prescaler's base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word (combinational) |
| rtc_tick | input | 1 | One-cycle tick pulse from the RTC |
| ext_tick | input | 1 | One-cycle external tick pulse |
| irq | output | 3 | Per-channel underflow interrupt |

## Verification
A write takes effect at the clock edge that samples it. Read data is combinational, so the bench drives every access and tick pulse at the falling edge and reads one cycle later, after exactly one edge has applied it. A tick pulse and a simultaneous count write share one edge, and this is how the bench tests the write-priority rule. The interrupt lines follow the flag and enable registers in the same cycle as the control read-back, so both are sampled together. Prescaler periods cannot be checked against a fixed phase. The bench instead polls the count every cycle and measures the distance between two successive decrements.

// File: rtl/tmr3_pkg.sv
package tmr3_pkg;
  localparam int unsigned N_CH     = 3;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 6;
  localparam int unsigned WORD_W   = ADDR_W - 2;
  localparam int unsigned N_TAPS   = 6;          // divide by 4^1 .. 4^6
  localparam int unsigned PRE_W    = 2 * N_TAPS;
  localparam int unsigned IE_BIT   = 5;
  localparam int unsigned UF_BIT   = 8;

  typedef enum logic [2:0] {
    SRC_DIV4    = 3'd0,
    SRC_DIV16   = 3'd1,
    SRC_DIV64   = 3'd2,
    SRC_DIV256  = 3'd3,
    SRC_DIV1K   = 3'd4,
    SRC_DIV4K   = 3'd5,
    SRC_RTC     = 3'd6,
    SRC_EXT     = 3'd7
  } tick_src_e;
endpackage

// File: rtl/tmr3_prescale.sv
module tmr3_prescale
  import tmr3_pkg::*;
#(
  parameter int unsigned TAPS = N_TAPS
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TAPS-1:0] tap
);
  localparam int unsigned CW = 2 * TAPS;

  logic [CW-1:0] div_q, div_d;

  always_comb begin
    div_d = div_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // tap k fires once every 4^(k+1) cycles: low 2(k+1) bits all ones
  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    assign tap[k] = &div_q[2*k+1:0];
  end

  // R8: the fastest tap never fires on two cycles in a row
  p_tap_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tap[0] |=> !tap[0]);
endmodule

// File: rtl/tmr3_chan.sv
module tmr3_chan
  import tmr3_pkg::*;
#(
  parameter int unsigned DW   = DATA_W,
  parameter int unsigned TAPS = N_TAPS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [TAPS-1:0] tap,
  input  logic            rtc_tick,
  input  logic            ext_tick,
  input  logic            rld_we,
  input  logic            cnt_we,
  input  logic            ctl_we,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rld_rd,
  output logic [DW-1:0]   cnt_rd,
  output logic [DW-1:0]   ctl_rd,
  output logic            irq
);
  tick_src_e      src_q, src_d;
  logic           ie_q, ie_d;
  logic           uf_q, uf_d;
  logic [DW-1:0]  rld_q, rld_d;
  logic [DW-1:0]  cnt_q, cnt_d;
  logic           tick, step, uf_evt, cnt_en, uf_clr;

  // tick source selection
  always_comb begin
    unique case (src_q)
      SRC_DIV4:   tick = tap[0];
      SRC_DIV16:  tick = tap[1];
      SRC_DIV64:  tick = tap[2];
      SRC_DIV256: tick = tap[3];
      SRC_DIV1K:  tick = tap[4];
      SRC_DIV4K:  tick = tap[TAPS-1];
      SRC_RTC:    tick = rtc_tick;
      SRC_EXT:    tick = ext_tick;
      default:    tick = 1'b0;
    endcase
  end

  // next-state
  always_comb begin
    step   = run & tick;
    uf_evt = step & (cnt_q == '0) & ~cnt_we;
    cnt_en = cnt_we | step;
    uf_clr = ctl_we & ~wdata[UF_BIT];

    rld_d  = wdata;
    src_d  = tick_src_e'(wdata[2:0]);
    ie_d   = wdata[IE_BIT];

    if (cnt_we)             cnt_d = wdata;
    else if (cnt_q == '0)   cnt_d = rld_q;
    else                    cnt_d = cnt_q - DW'(1);

    uf_d = uf_evt | (uf_q & ~uf_clr);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rld_q <= '0;
      cnt_q <= '0;
      src_q <= SRC_DIV4;
      ie_q  <= 1'b0;
      uf_q  <= 1'b0;
    end else begin
      if (rld_we) rld_q <= rld_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (ctl_we) begin
        src_q <= src_d;
        ie_q  <= ie_d;
      end
      uf_q <= uf_d;
    end
  end

  always_comb begin
    ctl_rd         = '0;
    ctl_rd[2:0]    = src_q;
    ctl_rd[IE_BIT] = ie_q;
    ctl_rd[UF_BIT] = uf_q;
  end

  assign rld_rd = rld_q;
  assign cnt_rd = cnt_q;
  assign irq    = uf_q & ie_q;

  // R10: a count write always lands as written
  p_cnt_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> cnt_q == $past(wdata));

  // R4: a stopped channel without a write keeps its count
  p_stop_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_we) |=> $stable(cnt_q));

  // R3: a tick on a non-zero count takes off exactly one
  p_decrement_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !cnt_we && cnt_q != '0) |=> cnt_q == $past(cnt_q) - DW'(1));

  // R5: a tick at zero reloads and flags
  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !cnt_we && cnt_q == '0) |=> (cnt_q == $past(rld_q)) && uf_q);

  // R6: the flag only rises through an underflow
  p_flag_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uf_q) |-> $past(run && tick && !cnt_we && cnt_q == '0));

  // R7: the interrupt only rises after an underflow or a control write
  p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(uf_evt || ctl_we));
endmodule

// File: rtl/tmr3_top.sv
module tmr3_top
  import tmr3_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rtc_tick,
  input  logic              ext_tick,
  output logic [N_CH-1:0]   irq
);
  // reset: asynchronous assertion, synchronous release
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  // address decode
  logic [WORD_W-1:0] word;
  logic              aligned, wr_en;
  assign word    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_en   = bus_sel & bus_wr & aligned;

  // start register
  logic [N_CH-1:0] run_q, run_d;
  logic            run_we;
  assign run_we = wr_en & (word == '0);
  assign run_d  = bus_wdata[N_CH-1:0];

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)      run_q <= '0;
    else if (run_we) run_q <= run_d;
  end

  // shared prescaler
  logic [N_TAPS-1:0] tap;
  tmr3_prescale #(.TAPS(N_TAPS)) u_pre (
    .clk   (clk),
    .rst_n (rst_s),
    .tap   (tap)
  );

  // channels
  logic [DATA_W-1:0] rld_rd [N_CH];
  logic [DATA_W-1:0] cnt_rd [N_CH];
  logic [DATA_W-1:0] ctl_rd [N_CH];

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    localparam logic [WORD_W-1:0] BASE = WORD_W'(1 + 3 * i);
    logic rld_we, cnt_we, ctl_we;
    assign rld_we = wr_en & (word == BASE);
    assign cnt_we = wr_en & (word == BASE + WORD_W'(1));
    assign ctl_we = wr_en & (word == BASE + WORD_W'(2));

    tmr3_chan #(.DW(DATA_W), .TAPS(N_TAPS)) u_ch (
      .clk      (clk),
      .rst_n    (rst_s),
      .run      (run_q[i]),
      .tap      (tap),
      .rtc_tick (rtc_tick),
      .ext_tick (ext_tick),
      .rld_we   (rld_we),
      .cnt_we   (cnt_we),
      .ctl_we   (ctl_we),
      .wdata    (bus_wdata),
      .rld_rd   (rld_rd[i]),
      .cnt_rd   (cnt_rd[i]),
      .ctl_rd   (ctl_rd[i]),
      .irq      (irq[i])
    );
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      if (word == '0) bus_rdata[N_CH-1:0] = run_q;
      for (int i = 0; i < N_CH; i++) begin
        if (word == WORD_W'(1 + 3 * i))      bus_rdata = rld_rd[i];
        else if (word == WORD_W'(2 + 3 * i)) bus_rdata = cnt_rd[i];
        else if (word == WORD_W'(3 + 3 * i)) bus_rdata = ctl_rd[i];
      end
    end
  end

  // R2: a start-word write lands in the run bits
  p_start_write_r2: assert property (@(posedge clk) disable iff (!rst_s)
    run_we |=> run_q == $past(bus_wdata[N_CH-1:0]));

  // R1: interrupts are low while the design is held in reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_s |-> irq == '0);
endmodule

// File: tb/tb_tmr3_top.sv
module tb_tmr3_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        rtc_tick, ext_tick;
  logic [2:0]  irq;

  int pass_n = 0, total_n = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  tmr3_top dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rtc_tick(rtc_tick), .ext_tick(ext_tick), .irq(irq)
  );

  // {is_write, addr, data, expected}
  localparam int NV = 15;
  localparam logic [70:0] VEC [NV] = '{
    {1'b1, 6'h04, 32'h0000_0010, 32'h0},
    {1'b0, 6'h04, 32'h0,         32'h0000_0010},
    {1'b1, 6'h08, 32'h0000_0005, 32'h0},
    {1'b0, 6'h08, 32'h0,         32'h0000_0005},
    {1'b1, 6'h0C, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 6'h0C, 32'h0,         32'h0000_0027},
    {1'b1, 6'h10, 32'hDEAD_BEEF, 32'h0},
    {1'b0, 6'h10, 32'h0,         32'hDEAD_BEEF},
    {1'b1, 6'h24, 32'h0000_0106, 32'h0},
    {1'b0, 6'h24, 32'h0,         32'h0000_0006},
    {1'b0, 6'h2C, 32'h0,         32'h0},
    {1'b1, 6'h00, 32'hFFFF_FFF8, 32'h0},
    {1'b0, 6'h00, 32'h0,         32'h0},
    {1'b1, 6'h0E, 32'h1234_5678, 32'h0},
    {1'b0, 6'h0E, 32'h0,         32'h0}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total_n++;
    if (got === exp) pass_n++;
    else $display("FAIL %s: got %h expected %h", req, got, exp);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wr_ext(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; ext_tick = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; ext_tick = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse(input bit use_ext);
    @(negedge clk);
    if (use_ext) ext_tick = 1'b1; else rtc_tick = 1'b1;
    @(negedge clk);
    ext_tick = 1'b0; rtc_tick = 1'b0;
  endtask

  task automatic expect_rd(input string req, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  // distance in cycles between two successive decrements of ch2 count
  task automatic measure(input string req, input int exp);
    logic [31:0] prev, cur;
    int t1 = -1, t2 = -1;
    rd(6'h20, prev);
    for (int c = 0; c < 3 * exp + 8 && t2 < 0; c++) begin
      rd(6'h20, cur);
      if (cur != prev) begin
        if (t1 < 0) t1 = c; else t2 = c;
      end
      prev = cur;
    end
    check(req, 32'(t2 - t1), 32'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total_n++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", pass_n, total_n);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    rtc_tick = 1'b0; ext_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 10; a++) expect_rd("R1 reg", 6'(a * 4), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);

    // R2: register map vectors
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][70]) wr(VEC[i][69:64], VEC[i][63:32]);
      else            expect_rd("R2 map", VEC[i][69:64], VEC[i][31:0]);
    end

    // R3/R9: ch0 on external tick
    wr(6'h00, 32'h1);
    repeat (3) pulse(1'b1);
    expect_rd("R3 ext decrement", 6'h08, 32'h2);
    pulse(1'b0);
    expect_rd("R9 rtc ignored by ext channel", 6'h08, 32'h2);

    // R9/R11: ch1 on RTC tick
    wr(6'h18, 32'h6);
    wr(6'h14, 32'h3);
    wr(6'h00, 32'h3);
    pulse(1'b0);
    expect_rd("R9 rtc decrement", 6'h14, 32'h2);
    expect_rd("R11 ch0 untouched", 6'h08, 32'h2);
    wr(6'h00, 32'h1);

    // R5/R7: underflow
    repeat (2) pulse(1'b1);
    expect_rd("R5 at zero", 6'h08, 32'h0);
    expect_rd("R5 no flag yet", 6'h0C, 32'h27);
    check("R7 irq low", 32'(irq[0]), 32'h0);
    pulse(1'b1);
    expect_rd("R5 reload", 6'h08, 32'h10);
    expect_rd("R5 flag set", 6'h0C, 32'h127);
    check("R7 irq high", 32'(irq[0]), 32'h1);

    // R6/R7: flag write rules
    wr(6'h0C, 32'h107);
    expect_rd("R6 flag kept", 6'h0C, 32'h107);
    check("R7 irq off by enable", 32'(irq[0]), 32'h0);
    wr(6'h0C, 32'h127);
    check("R7 irq back", 32'(irq[0]), 32'h1);
    wr(6'h0C, 32'h027);
    expect_rd("R6 flag cleared", 6'h0C, 32'h027);
    check("R7 irq off by flag", 32'(irq[0]), 32'h0);
    wr(6'h0C, 32'h127);
    expect_rd("R6 write cannot set", 6'h0C, 32'h027);
    check("R6 irq stays low", 32'(irq[0]), 32'h0);

    // R4: stopped channel holds
    wr(6'h00, 32'h0);
    repeat (2) pulse(1'b1);
    expect_rd("R4 frozen", 6'h08, 32'h10);

    // R10: write priority
    wr(6'h00, 32'h1);
    wr_ext(6'h08, 32'h77);
    expect_rd("R10 write over decrement", 6'h08, 32'h77);
    wr(6'h08, 32'h0);
    wr_ext(6'h08, 32'h9);
    expect_rd("R10 write over reload", 6'h08, 32'h9);
    expect_rd("R10 no flag", 6'h0C, 32'h027);

    // R8: prescaler periods on ch2
    wr(6'h00, 32'h4);
    wr(6'h24, 32'h0);
    wr(6'h20, 32'h1000);
    measure("R8 div4", 4);
    wr(6'h24, 32'h2);
    measure("R8 div64", 64);
    wr(6'h24, 32'h5);
    measure("R8 code5 div4096", 4096);
    expect_rd("R11 ch0 unchanged", 6'h08, 32'h9);

    done = 1'b1;
    $display("%0d/%0d checks passed", pass_n, total_n);
    $finish;
  end
endmodule